// File: doc/BRIEF.md
# Minimum-Energy Inversion Burst Encoder

This block encodes a burst of eight bytes for a pseudo-open-drain memory data lane. Each byte travels with one extra inversion wire. The block picks the inversion pattern for the whole burst that gives the lowest total wire energy. The energy counts two things, each weighted by its own small integer coefficient: the low levels driven on all nine wires of every beat, and the level changes from one beat to the next. Deciding each byte on its own cannot always reach that minimum, so the block runs a two-state trellis search across the burst.

Every byte has its own add-compare-select stage. The stage forms the edge costs from two popcounts: one of the byte itself and one of its XOR with the previous raw byte. It adds those edge costs to the two running path costs and keeps the cheaper incoming path for each state, recording which one it kept. A traceback stage then picks the cheaper end state and follows the recorded choices backwards to produce the inversion bits.

A full burst is accepted every cycle. The coefficients come in with the burst. The encoded bytes, the inversion bits and the minimum cost appear two clock edges later.

Top module: `dbi_burst_encoder`

## Requirements
- R1: While reset is held low at a clock edge, out_valid, out_data, out_dbi_n and out_cost all become zero.
- R2: A burst taken with in_valid high at edge k gives out_valid high after edge k+2, with its results. A new burst may be taken at every edge, and out_valid is low for cycles with no burst.
- R3: Byte i occupies in_burst[8i+7:8i], and byte 0 is sent first. Each out_data byte equals the raw byte when its out_dbi_n bit is 1, and the bitwise inverse of the raw byte when that bit is 0.
- R4: The cost of a pattern is alpha times the number of level changes plus beta times the number of zeros, counted over all nine wires of the eight beats. Before the burst, all nine wires are taken to be at one.
- R5: out_cost equals the minimum cost over all 256 inversion patterns, for any alpha and beta in the range 0 to 7.
- R6: out_cost equals the cost of the pattern actually reported on out_dbi_n and out_data.
- R7: On equal path costs, the non-inverted predecessor is kept. On equal end costs, the non-inverted end state is chosen. So with alpha=beta=0 every out_dbi_n bit is 1 and the cost is 0.
- R8: With alpha=beta=1, the burst with bytes 8E 86 96 E9 7D B7 57 C4 (first to last) costs 52.
- R9: An all-ones burst costs 0 with no inversion. An all-zeros burst with alpha=0 and beta=1 inverts every byte and costs 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Burst present this cycle |
| in_burst | input | 8*NB | Raw burst, byte 0 in the low bits |
| in_alpha | input | CW | Cost per level change |
| in_beta | input | CW | Cost per zero driven |
| out_valid | output | 1 | Results valid |
| out_data | output | 8*NB | Encoded bytes |
| out_dbi_n | output | NB | Inversion wire per byte, 0 means inverted |
| out_cost | output | COST_W | Minimum burst cost |

## Verification
On every cycle, the assertions check several properties. Each out_data byte must agree with its inversion bit and the raw byte taken two edges earlier. out_valid must follow in_valid by two edges. A reported cost can never be the saturated infinite value. No finite path may turn infinite inside a stage. The tie rules must hold at every select and at the final pick. Only the bench scenarios can show that the reported cost is truly minimal over all 256 patterns, and that it matches the cost of the pattern reported. The bench does this by an exhaustive search over all patterns for random bursts and for extreme coefficients, and by checking the reference burst and the degenerate bursts.

// File: rtl/dbi_pkg.sv
// Shared helpers for the burst inversion encoder.
// Assumes byte-wide lanes; nothing here holds state.
package dbi_pkg;

    localparam int LANE_W = 8;

    // Count the set bits in one byte.
    function automatic logic [3:0] pop8(input logic [LANE_W-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int k = 0; k < LANE_W; k++) n = n + {3'b000, v[k]};
        return n;
    endfunction

endpackage

// File: rtl/dbi_acs_stage.sv
// One trellis stage: this is the add-compare-select for a single byte.
// It assumes the incoming costs are either finite or saturated all-ones (infinite),
// and that COST_W leaves headroom so that no finite sum ever reaches all-ones.
module dbi_acs_stage #(
    parameter int CW     = 3,
    parameter int COST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cur_byte,
    input  logic [7:0]        prev_byte,
    input  logic [CW-1:0]     alpha,
    input  logic [CW-1:0]     beta,
    input  logic [COST_W-1:0] cost_n_in,
    input  logic [COST_W-1:0] cost_i_in,
    output logic [COST_W-1:0] cost_n_out,
    output logic [COST_W-1:0] cost_i_out,
    output logic              sel_n,
    output logic              sel_i
);
    import dbi_pkg::*;

    localparam logic [COST_W-1:0] INF = '1;

    logic [3:0]        ones_x, diff_y;
    logic [COST_W-1:0] a_w, b_w, ac_same, ac_flip, dc_keep, dc_inv;
    logic [COST_W-1:0] c_nn, c_in, c_ni, c_ii;

    // Saturating add: an infinite path stays infinite.
    function automatic logic [COST_W-1:0] sadd(input logic [COST_W-1:0] p,
                                               input logic [COST_W-1:0] e);
        if (p == INF) return INF;
        return p + e;
    endfunction

    // Edge costs from the two popcounts.
    always_comb begin
        ones_x  = pop8(cur_byte);
        diff_y  = pop8(cur_byte ^ prev_byte);
        a_w     = COST_W'(alpha);
        b_w     = COST_W'(beta);
        ac_same = a_w * COST_W'(diff_y);
        ac_flip = a_w * COST_W'(4'd9 - diff_y);
        dc_keep = b_w * COST_W'(4'd8 - ones_x);
        dc_inv  = b_w * COST_W'(ones_x + 4'd1);
    end

    // Four candidate sums, then keep the cheaper one per state (ties keep non-inverted).
    always_comb begin
        c_nn       = sadd(cost_n_in, ac_same + dc_keep);
        c_in       = sadd(cost_i_in, ac_flip + dc_keep);
        c_ni       = sadd(cost_n_in, ac_flip + dc_inv);
        c_ii       = sadd(cost_i_in, ac_same + dc_inv);
        sel_n      = (c_in < c_nn);
        sel_i      = (c_ii < c_ni);
        cost_n_out = sel_n ? c_in : c_nn;
        cost_i_out = sel_i ? c_ii : c_ni;
    end

    // R4: a finite non-inverted path must give finite costs to both next states.
    p_finite_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cost_n_in != INF) |-> (cost_n_out != INF && cost_i_out != INF));

    // R7: equal candidates must keep the non-inverted predecessor.
    p_tie_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_nn == c_in) |-> !sel_n);

    p_tie_keep_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ni == c_ii) |-> !sel_i);

endmodule

// File: rtl/dbi_traceback.sv
// Final compare and backtrack through the recorded select bits.
// It assumes sel_n[i]/sel_i[i] name the state of byte i-1 that was kept for state n/i of byte i.
module dbi_traceback #(
    parameter int NB     = 8,
    parameter int COST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     sel_n,
    input  logic [NB-1:0]     sel_i,
    input  logic [COST_W-1:0] end_n,
    input  logic [COST_W-1:0] end_i,
    output logic [NB-1:0]     inv_mask,
    output logic [COST_W-1:0] best_cost
);
    logic st;

    // Pick the end state (tie keeps non-inverted), then walk back to byte 0.
    always_comb begin
        st        = (end_i < end_n);
        best_cost = st ? end_i : end_n;
        inv_mask  = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            inv_mask[i] = st;
            st          = st ? sel_i[i] : sel_n[i];
        end
    end

    // R7: equal end costs must end in the non-inverted state.
    p_end_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_n == end_i) |-> !inv_mask[NB-1]);

    // R5: the result is never worse than either end state.
    p_end_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (best_cost <= end_n) && (best_cost <= end_i));

endmodule

// File: rtl/dbi_burst_encoder.sv
// Minimum-energy inversion encoder for a burst of NB bytes.
// Registers the burst and coefficients, runs a combinational trellis over NB
// add-compare-select stages, backtracks, and registers the results:
// two edges from input to output, one burst per cycle.
// Assumes the virtual beat before the burst is all ones with the inversion wire at one.
module dbi_burst_encoder #(
    parameter int NB     = 8,
    parameter int CW     = 3,
    parameter int COST_W = $clog2(NB * 18 * ((1 << CW) - 1) + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [8*NB-1:0]   in_burst,
    input  logic [CW-1:0]     in_alpha,
    input  logic [CW-1:0]     in_beta,
    output logic              out_valid,
    output logic [8*NB-1:0]   out_data,
    output logic [NB-1:0]     out_dbi_n,
    output logic [COST_W-1:0] out_cost
);
    localparam logic [COST_W-1:0] INF = '1;

    logic              v1;
    logic [8*NB-1:0]   burst_q;
    logic [CW-1:0]     alpha_q, beta_q;

    logic [COST_W-1:0] cn [0:NB];
    logic [COST_W-1:0] ci [0:NB];
    logic [NB-1:0]     sel_n, sel_i, inv_mask;
    logic [COST_W-1:0] best_cost;
    logic [8*NB-1:0]   enc_comb;

    // Input register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1      <= 1'b0;
            burst_q <= '0;
            alpha_q <= '0;
            beta_q  <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                burst_q <= in_burst;
                alpha_q <= in_alpha;
                beta_q  <= in_beta;
            end
        end
    end

    // Start node: non-inverted state costs nothing, inverted state is unreachable.
    assign cn[0] = '0;
    assign ci[0] = INF;

    // One stage per byte; the predecessor of byte 0 is the all-ones beat.
    for (genvar g = 0; g < NB; g++) begin : g_stage
        logic [7:0] prev_b;
        if (g == 0) begin : g_first
            assign prev_b = 8'hFF;
        end else begin : g_rest
            assign prev_b = burst_q[8*(g-1) +: 8];
        end

        dbi_acs_stage #(.CW(CW), .COST_W(COST_W)) u_acs (
            .clk       (clk),
            .rst_n     (rst_n),
            .cur_byte  (burst_q[8*g +: 8]),
            .prev_byte (prev_b),
            .alpha     (alpha_q),
            .beta      (beta_q),
            .cost_n_in (cn[g]),
            .cost_i_in (ci[g]),
            .cost_n_out(cn[g+1]),
            .cost_i_out(ci[g+1]),
            .sel_n     (sel_n[g]),
            .sel_i     (sel_i[g])
        );

        assign enc_comb[8*g +: 8] = burst_q[8*g +: 8] ^ {8{inv_mask[g]}};
    end

    dbi_traceback #(.NB(NB), .COST_W(COST_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sel_i    (sel_i),
        .end_n    (cn[NB]),
        .end_i    (ci[NB]),
        .inv_mask (inv_mask),
        .best_cost(best_cost)
    );

    // Output register stage; results hold between bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_dbi_n <= '0;
            out_cost  <= '0;
        end else begin
            out_valid <= v1;
            if (v1) begin
                out_data  <= enc_comb;
                out_dbi_n <= ~inv_mask;
                out_cost  <= best_cost;
            end
        end
    end

    // R2: results appear exactly two edges after a burst is taken.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R5: a reported cost is always a reachable, finite cost.
    p_cost_finite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cost != INF));

    // R3: every output byte agrees with its inversion bit and the raw byte.
    for (genvar g = 0; g < NB; g++) begin : g_chk
        p_byte_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ((out_data[8*g +: 8] ^ {8{~out_dbi_n[g]}}) == $past(burst_q[8*g +: 8])));
    end

endmodule

// File: tb/sim_dbi_burst_encoder.sv
module sim_dbi_burst_encoder;
    localparam int NB     = 8;
    localparam int CW     = 3;
    localparam int COST_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [8*NB-1:0]   in_burst = '0;
    logic [CW-1:0]     in_alpha = '0;
    logic [CW-1:0]     in_beta = '0;
    logic              out_valid;
    logic [8*NB-1:0]   out_data;
    logic [NB-1:0]     out_dbi_n;
    logic [COST_W-1:0] out_cost;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        logic [8*NB-1:0] burst;
        int              a;
        int              b;
        int              exp_cost;
        bit              has_dbi;
        logic [NB-1:0]   exp_dbi;
        int              due;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbi_burst_encoder #(.NB(NB), .CW(CW), .COST_W(COST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_burst(in_burst),
        .in_alpha(in_alpha), .in_beta(in_beta), .out_valid(out_valid),
        .out_data(out_data), .out_dbi_n(out_dbi_n), .out_cost(out_cost)
    );

    // Reference cost of one pattern (mask bit 1 = byte inverted), per R4.
    function automatic int pat_cost(logic [8*NB-1:0] bu, logic [NB-1:0] m, int a, int b);
        logic [8:0] prev, w;
        int z, t;
        prev = 9'h1FF; z = 0; t = 0;
        for (int i = 0; i < NB; i++) begin
            w = {~m[i], bu[8*i +: 8] ^ {8{m[i]}}};
            z += 9 - $countones(w);
            t += $countones(w ^ prev);
            prev = w;
        end
        return a * t + b * z;
    endfunction

    function automatic int best_cost(logic [8*NB-1:0] bu, int a, int b);
        int best, c;
        best = 1 << 30;
        for (int m = 0; m < (1 << NB); m++) begin
            c = pat_cost(bu, NB'(m), a, b);
            if (c < best) best = c;
        end
        return best;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: apply one burst at the falling edge and push its expectation.
    task automatic send(logic [8*NB-1:0] bu, int a, int b, bit has_dbi = 0,
                        logic [NB-1:0] ed = '1, int force_cost = -1);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_burst = bu; in_alpha = CW'(a); in_beta = CW'(b);
        it.burst = bu; it.a = a; it.b = b;
        it.exp_cost = (force_cost >= 0) ? force_cost : best_cost(bu, a, b);
        it.has_dbi = has_dbi; it.exp_dbi = ed; it.due = cyc + 2;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each result against the head of the scoreboard.
    initial begin
        item_t it;
        logic [NB-1:0] m;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected out_valid", 1, 0);
                end else begin
                    it = sb.pop_front();
                    m = ~out_dbi_n;
                    check(cyc == it.due, "R2", "latency", cyc, it.due);
                    check(out_cost == COST_W'(it.exp_cost), "R5", "min cost", out_cost, it.exp_cost);
                    check(out_data == (it.burst ^ {{8{m[7]}}, {8{m[6]}}, {8{m[5]}}, {8{m[4]}},
                                                   {8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}}),
                          "R3", "encoded data", out_data, it.burst);
                    check(pat_cost(it.burst, m, it.a, it.b) == int'(out_cost), "R6",
                          "pattern cost", pat_cost(it.burst, m, it.a, it.b), out_cost);
                    if (it.has_dbi)
                        check(out_dbi_n == it.exp_dbi, "R7/R9", "dbi pattern", out_dbi_n, it.exp_dbi);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: drive junk during reset and then check the reset state.
        in_valid = 1'b1; in_burst = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(out_data == '0 && out_dbi_n == '0, "R1", "data in reset", out_data, 0);
        check(out_cost == '0, "R1", "cost in reset", out_cost, 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R8: reference burst, byte 0 first.
        send(64'hC457B77DE996868E, 1, 1, 0, '1, 52);
        // R9: all ones, no inversion, zero cost.
        send('1, 1, 1, 1, 8'hFF, 0);
        // R9: all zeros with zero-only cost inverts every byte.
        send('0, 0, 1, 1, 8'h00, 8);
        // R7: zero coefficients, ties everywhere.
        send(64'h0123456789ABCDEF, 0, 0, 1, 8'hFF, 0);
        send(64'h00FF00FF0F0F3C3C, 0, 0, 1, 8'hFF, 0);
        idle(3);

        // R4/R5: pure transition cost, pure zero cost and extreme coefficients.
        send(64'h00FF00FF00FF00FF, 1, 0);
        send(64'h0000000000000000, 0, 1);
        send(64'h0000000000000000, 7, 7);
        send(64'h5A5A5A5AA5A5A5A5, 7, 7);
        send(64'h0F0F0F0F0F0F0F0F, 7, 1);
        send(64'h8001800180018001, 1, 7);
        idle(1);

        // R5/R6: random bursts and coefficients, back to back and with gaps.
        for (int n = 0; n < 120; n++) begin
            send({$urandom, $urandom}, $urandom_range(0, 7), $urandom_range(0, 7));
            if (n % 17 == 0) idle(2);
        end
        idle(6);

        check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
        check(out_valid == 1'b0, "R2", "out_valid idle", out_valid, 0);

        done = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule